// File: doc/BRIEF.md
# Adjustable Time-of-Day Counter for Precision Time Protocol

This block keeps a free-running 54-bit time-of-day value whose least significant bit is 2^-8 ns. Below that bit it keeps a 32-bit fraction that software cannot see. On every rising clock edge the combined 86-bit accumulator grows by a 64-bit increment. The upper half of the increment is in units of 2^-8 ns and the lower half is in units of 2^-40 ns. A servo outside the block steers the counter through two ports.

The load port replaces the time with an absolute value. A load happens when the load-arm input is high and the sync line changes level, in either direction. The sync line is also sampled on the falling clock edge. If the new level was already seen there, the loaded value is raised by half of the current increment, because the request really came half a period earlier.

The adjustment port takes a one-cycle strobe, a 2-bit mode and a 32-bit value. Three modes are defined. The coarse mode replaces the increment and clears its sub-nanosecond part. The fine mode adds a signed trim to the increment, and the trim stays in effect. The phase mode changes a single update only.

Top module: `ptp_tod_timer`

## Requirements
- R1: While reset is asserted, and on the two rising edges after it is released, the time output stays 0. The increment register restarts at the RESET_INC parameter (default: 1024 in the 2^-8 ns half, 0 in the fraction half).
- R2: On any other rising edge with no load and no phase step, the 86-bit value {time, fraction} grows by the 64-bit increment. The time output wraps modulo 2^54.
- R3: When load_arm_i is high and load_sync_i has changed level since the previous rising edge (0 to 1 or 1 to 0), the time becomes load_value_i and the fraction becomes 0 after that edge. No increment is added on that edge.
- R4: A sync change while load_arm_i is low has no effect, and a high load_arm_i without a sync change has no effect.
- R5: When the new sync level was already captured at the falling edge before the loading rising edge, the loaded value is {load_value_i, 32'b0} plus the pre-edge increment register shifted right by one.
- R6: An adjustment strobe sampled at rising edge E acts on the update at edge E+1. The mode encoding is 2'b01 phase, 2'b10 coarse, 2'b11 fine. Mode 2'b00 changes nothing.
- R7: Coarse mode sets the increment to {adj_value_i, 32'h0}. This discards any earlier fine trim.
- R8: Fine mode adds the sign-extended 32-bit adj_value_i to the 64-bit increment. The new increment is used on E+1 and on every later update, and successive trims accumulate.
- R9: Phase mode takes adj_value_i[17:0] as a two's-complement count of 2^-8 ns and adds it to the time on the E+1 update only. The upper value bits are ignored and the increment register does not change.
- R10: A strobe sampled on the same rising edge as a load is discarded.
- R11: When a load happens on the edge where an earlier strobe takes effect, a coarse or fine increment change still takes effect and a phase step is lost. The loaded time is as in R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_arm_i | input | 1 | Enables a load on the next sync level change |
| load_value_i | input | 54 | Time to load, units of 2^-8 ns |
| load_sync_i | input | 1 | Level change triggers the load |
| adj_valid_i | input | 1 | One-cycle adjustment strobe |
| adj_mode_i | input | 2 | Adjustment mode (01 phase, 10 coarse, 11 fine) |
| adj_value_i | input | 32 | Adjustment operand |
| tod_o | output | 54 | Current time, units of 2^-8 ns |

## Verification
The assertions assume that load_sync_i changes at most once per clock period and that it never goes back to its old level between the falling edge and the following rising edge. They assume this because the early-capture flag is only meaningful when the falling-edge sample agrees with the level seen at the rising edge. The bench satisfies this by changing sync either just after a rising edge or just after a falling edge, never twice in one period. Its random phase changes sync at most once per cycle, picks the early or late position at random, and leaves all other inputs steady across each rising edge.

// File: rtl/ptp_tmr_pkg.sv
package ptp_tmr_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    ADJ_NONE   = 2'b00,
    ADJ_PHASE  = 2'b01,
    ADJ_COARSE = 2'b10,
    ADJ_FINE   = 2'b11
  } adj_mode_e;

endpackage

// File: rtl/ptp_rst_sync.sv
module ptp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/ptp_sync_edge.sv
module ptp_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic arm_i,
  output logic fire_o,
  output logic half_o
);

  logic neg_q;
  logic pos_q;
  logic toggle;
  logic early;

  // sample taken half a period before the rising edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
    end else begin
      neg_q <= sync_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 1'b0;
    end else begin
      pos_q <= sync_i;
    end
  end

  always_comb begin
    toggle = sync_i ^ pos_q;
    early  = neg_q ^ pos_q;
    fire_o = toggle & arm_i;
    half_o = fire_o & early;
  end

  AST_SYNC_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_q != pos_q) |-> (sync_i == neg_q)); // R5

endmodule

// File: rtl/ptp_incr_ctrl.sv
module ptp_incr_ctrl
  import ptp_tmr_pkg::*;
#(
  parameter int ADJ_W   = 32,
  parameter int FRAC_W  = 32,
  parameter int PHASE_W = 18,
  parameter logic [ADJ_W+FRAC_W-1:0] RESET_INC = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adj_valid_i,
  input  logic [MODE_W-1:0]         adj_mode_i,
  input  logic [ADJ_W-1:0]          adj_value_i,
  input  logic                      drop_i,
  output logic [ADJ_W+FRAC_W-1:0]   inc_eff_o,
  output logic [ADJ_W+FRAC_W-1:0]   inc_base_o,
  output logic [PHASE_W-1:0]        phase_o
);

  localparam int INC_W = ADJ_W + FRAC_W;
  localparam int EXT_W = INC_W - ADJ_W;

  logic              pend_q, pend_d;
  adj_mode_e         pmode_q, pmode_d;
  logic [ADJ_W-1:0]  pval_q, pval_d;
  logic [INC_W-1:0]  inc_q;

  // next-state for the command stage
  always_comb begin
    pend_d  = adj_valid_i & ~drop_i;
    pmode_d = adj_mode_e'(adj_mode_i);
    pval_d  = adj_value_i;
  end

  // effective increment for the current update
  always_comb begin
    inc_eff_o = inc_q;
    phase_o   = '0;
    if (pend_q) begin
      case (pmode_q)
        ADJ_COARSE: inc_eff_o = {pval_q, {FRAC_W{1'b0}}};
        ADJ_FINE:   inc_eff_o = inc_q + {{EXT_W{pval_q[ADJ_W-1]}}, pval_q};
        ADJ_PHASE:  phase_o   = pval_q[PHASE_W-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmode_q <= ADJ_NONE;
      pval_q  <= '0;
    end else if (adj_valid_i) begin
      pmode_q <= pmode_d;
      pval_q  <= pval_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= RESET_INC;
    end else if (pend_q) begin
      inc_q <= inc_eff_o;
    end
  end

  assign inc_base_o = inc_q;

  AST_COARSE_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && pmode_q == ADJ_COARSE) |=> (inc_q[FRAC_W-1:0] == '0)); // R7

  AST_COARSE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && pmode_q == ADJ_COARSE) |=> (inc_q[INC_W-1:FRAC_W] == $past(pval_q))); // R7

  AST_PHASE_KEEPS_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && pmode_q == ADJ_PHASE) |=> $stable(inc_q)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(inc_q)); // R6

endmodule

// File: rtl/ptp_tod_accum.sv
module ptp_tod_accum #(
  parameter int TOD_W   = 54,
  parameter int FRAC_W  = 32,
  parameter int INC_W   = 64,
  parameter int PHASE_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               half_i,
  input  logic [TOD_W-1:0]   load_value_i,
  input  logic [INC_W-1:0]   inc_eff_i,
  input  logic [INC_W-1:0]   inc_base_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [TOD_W-1:0]   tod_o
);

  localparam int ACC_W  = TOD_W + FRAC_W;
  localparam int PEXT_W = ACC_W - PHASE_W - FRAC_W;
  localparam int IEXT_W = ACC_W - INC_W;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] comp;

  always_comb begin
    step = {{IEXT_W{1'b0}}, inc_eff_i}
         + {{PEXT_W{phase_i[PHASE_W-1]}}, phase_i, {FRAC_W{1'b0}}};
    comp = half_i ? {{IEXT_W{1'b0}}, (inc_base_i >> 1)} : '0;
    if (load_i) begin
      acc_d = {load_value_i, {FRAC_W{1'b0}}} + comp;
    end else begin
      acc_d = acc_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign tod_o = acc_q[ACC_W-1:FRAC_W];

  AST_TOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && (phase_i == '0)) |=>
      ((TOD_W'(tod_o - $past(tod_o)) == TOD_W'($past(inc_eff_i[INC_W-1:FRAC_W]))) ||
       (TOD_W'(tod_o - $past(tod_o)) == TOD_W'($past(inc_eff_i[INC_W-1:FRAC_W])) + TOD_W'(1)))); // R2

  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !half_i) |=> (tod_o == $past(load_value_i))); // R3

endmodule

// File: rtl/ptp_tod_timer.sv
module ptp_tod_timer
  import ptp_tmr_pkg::*;
#(
  parameter int TOD_W      = 54,
  parameter int FRAC_W     = 32,
  parameter int ADJ_W      = 32,
  parameter int PHASE_W    = 18,
  parameter int RST_STAGES = 2,
  parameter logic [ADJ_W+FRAC_W-1:0] RESET_INC = 64'h0000_0400_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_arm_i,
  input  logic [TOD_W-1:0]  load_value_i,
  input  logic              load_sync_i,
  input  logic              adj_valid_i,
  input  logic [MODE_W-1:0] adj_mode_i,
  input  logic [ADJ_W-1:0]  adj_value_i,
  output logic [TOD_W-1:0]  tod_o
);

  localparam int INC_W = ADJ_W + FRAC_W;

  logic               rst_n_s;
  logic               load_fire;
  logic               load_half;
  logic [INC_W-1:0]   inc_eff;
  logic [INC_W-1:0]   inc_base;
  logic [PHASE_W-1:0] phase_step;

  ptp_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  ptp_sync_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .sync_i (load_sync_i),
    .arm_i  (load_arm_i),
    .fire_o (load_fire),
    .half_o (load_half)
  );

  ptp_incr_ctrl #(
    .ADJ_W     (ADJ_W),
    .FRAC_W    (FRAC_W),
    .PHASE_W   (PHASE_W),
    .RESET_INC (RESET_INC)
  ) u_incr (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .adj_valid_i (adj_valid_i),
    .adj_mode_i  (adj_mode_i),
    .adj_value_i (adj_value_i),
    .drop_i      (load_fire),
    .inc_eff_o   (inc_eff),
    .inc_base_o  (inc_base),
    .phase_o     (phase_step)
  );

  ptp_tod_accum #(
    .TOD_W   (TOD_W),
    .FRAC_W  (FRAC_W),
    .INC_W   (INC_W),
    .PHASE_W (PHASE_W)
  ) u_acc (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .load_i       (load_fire),
    .half_i       (load_half),
    .load_value_i (load_value_i),
    .inc_eff_i    (inc_eff),
    .inc_base_i   (inc_base),
    .phase_i      (phase_step),
    .tod_o        (tod_o)
  );

endmodule

// File: tb/ptp_tod_timer_test.sv
`timescale 1ns/1ps
module ptp_tod_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        arm;
  logic [53:0] ldv;
  logic        sync;
  logic        av;
  logic [1:0]  am;
  logic [31:0] aval;
  logic [53:0] tod;

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R2";

  // reference model state
  logic [85:0] m_acc;
  logic [63:0] m_inc;
  logic        m_pend;
  logic [1:0]  m_mode;
  logic [31:0] m_val;
  logic        m_prev;
  logic        m_neg;
  logic        m_active;

  always #2 clk = ~clk;

  ptp_tod_timer uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_arm_i   (arm),
    .load_value_i (ldv),
    .load_sync_i  (sync),
    .adj_valid_i  (av),
    .adj_mode_i   (am),
    .adj_value_i  (aval),
    .tod_o        (tod)
  );

  always @(negedge clk) m_neg = sync;

  task automatic chk(input string tag, input logic [53:0] act, input logic [53:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic        toggle, early, fire;
    logic [63:0] eff;
    logic [85:0] phs;
    toggle = (sync != m_prev);
    early  = (m_neg != m_prev);
    fire   = toggle && arm;
    eff    = m_inc;
    phs    = '0;
    if (m_pend) begin
      case (m_mode)
        2'b10: eff = {m_val, 32'h0};
        2'b11: eff = m_inc + {{32{m_val[31]}}, m_val};
        2'b01: phs = {{36{m_val[17]}}, m_val[17:0], 32'h0};
        default: ;
      endcase
    end
    if (fire) m_acc = {ldv, 32'h0} + (early ? {22'h0, (m_inc >> 1)} : 86'h0);
    else      m_acc = m_acc + {22'h0, eff} + phs;
    m_inc  = eff;
    m_pend = av && !fire;
    if (av) begin
      m_mode = am;
      m_val  = aval;
    end
    m_prev = sync;
  endtask

  task automatic step();
    @(posedge clk);
    if (m_active) model_edge();
    #1;
    chk(cur_tag, tod, m_acc[85:32]);
  endtask

  task automatic strobe(input logic [1:0] mode, input logic [31:0] val);
    av = 1'b1; am = mode; aval = val;
    step();
    av = 1'b0;
  endtask

  task automatic toggle_late();
    #2;
    sync = ~sync;
    step();
  endtask

  task automatic toggle_early();
    sync = ~sync;
    step();
  endtask

  initial begin
    logic [53:0] t0;
    logic [31:0] r;
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; arm = 1'b0; ldv = '0; sync = 1'b0;
    av = 1'b0; am = 2'b00; aval = '0;
    m_acc = '0; m_inc = 64'h0000_0400_0000_0000; m_pend = 1'b0;
    m_mode = 2'b00; m_val = '0; m_prev = 1'b0; m_active = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", tod, 54'h0);
    rst_n = 1'b1;
    cur_tag = "R1";
    step();
    step();
    chk("R1 after release", tod, 54'h0);
    m_active = 1'b1;

    // R2 free run with default increment
    cur_tag = "R2";
    repeat (10) step();
    chk("R2 ten updates", tod, 54'd10240);

    // R7 coarse load
    cur_tag = "R7";
    strobe(2'b10, 32'h500);
    t0 = tod; step();
    chk("R7 coarse delta", tod - t0, 54'h500);

    // R8 fine trims accumulate
    cur_tag = "R8";
    strobe(2'b11, 32'h4000_0000);
    t0 = tod; repeat (4) step();
    chk("R8 fine quarter", tod - t0, 54'h1401);
    strobe(2'b11, 32'hE000_0000);
    t0 = tod; repeat (8) step();
    chk("R8 fine accumulated", tod - t0, 54'h2801);

    // R7 coarse discards fine trim
    cur_tag = "R7";
    strobe(2'b10, 32'h400);
    t0 = tod; repeat (5) step();
    chk("R7 coarse clears fine", tod - t0, 54'h1400);

    // R9 phase steps
    cur_tag = "R9";
    strobe(2'b01, 32'd1000);
    t0 = tod; step();
    chk("R9 phase step", tod - t0, 54'h400 + 54'd1000);
    t0 = tod; step();
    chk("R9 one shot", tod - t0, 54'h400);
    strobe(2'b01, 32'hABC2_0000);
    t0 = tod; step();
    chk("R9 negative min", tod - t0, 54'h400 - 54'd131072);
    t0 = tod; step();
    chk("R9 restored", tod - t0, 54'h400);

    // R6 mode 00 ignored
    cur_tag = "R6";
    strobe(2'b00, 32'hFFFF_FFFF);
    t0 = tod; repeat (3) step();
    chk("R6 mode none", tod - t0, 54'hC00);

    // R3 loads in both directions, R2 wrap
    cur_tag = "R3";
    arm = 1'b1; ldv = 54'h12_3456_789A;
    toggle_late();
    chk("R3 rising load", tod, 54'h12_3456_789A);
    step();
    chk("R3 after load", tod, 54'h12_3456_789A + 54'h400);
    ldv = 54'h3F_FFFF_FFFF_FF00;
    toggle_late();
    chk("R3 falling load", tod, 54'h3F_FFFF_FFFF_FF00);
    step();
    chk("R2 wrap", tod, 54'h300);

    // R5 falling-edge compensation
    cur_tag = "R5";
    strobe(2'b10, 32'h401);
    step();
    ldv = 54'h1000;
    toggle_early();
    chk("R5 half increment", tod, 54'h1200);
    step();
    chk("R5 half fraction", tod, 54'h1601);

    // R4 ignored loads
    cur_tag = "R4";
    arm = 1'b0; t0 = tod;
    toggle_late();
    chk("R4 sync without arm", tod - t0, 54'h401);
    arm = 1'b1; t0 = tod;
    step();
    chk("R4 arm without sync", tod - t0, 54'h401);

    // R10 strobe dropped by simultaneous load
    cur_tag = "R10";
    ldv = 54'h5000; av = 1'b1; am = 2'b10; aval = 32'h300;
    toggle_late();
    av = 1'b0;
    chk("R10 load value", tod, 54'h5000);
    step();
    chk("R10 strobe dropped", tod, 54'h5401);
    step();
    chk("R10 increment kept", tod, 54'h5802);

    // R11 pending coarse with load on the same edge
    cur_tag = "R11";
    strobe(2'b10, 32'h300);
    ldv = 54'h7000;
    toggle_late();
    chk("R11 load value", tod, 54'h7000);
    step();
    chk("R11 coarse survived", tod, 54'h7300);
    arm = 1'b0;

    // random phase
    cur_tag = "R2 random";
    for (int i = 0; i < 3000; i++) begin
      logic late;
      r = $urandom;
      late = 1'b0;
      arm = r[13];
      if (r[3:0] == 4'h0) begin
        av = 1'b1; am = r[5:4]; aval = $urandom;
      end
      if (r[10:6] == 5'h0) begin
        arm = r[11];
        ldv = 54'({$urandom, $urandom});
        late = r[12];
        if (!late) sync = ~sync;
      end
      if (late) toggle_late();
      else step();
      av = 1'b0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule